// File: doc/BRIEF.md
# Instruction-Count Debug Trigger Unit

This unit holds a small bank of debug triggers that fire after a programmed number of retired instructions. Each trigger is one 32-bit control word. Software selects a word by index, reads it back on a combinational read port, and overwrites it with a write strobe. The core feeds in three things: a retire strobe, the current privilege level and a flag for virtualized mode.

On every retired instruction, each armed trigger whose privilege enables match the current mode counts down by one. A trigger is armed when it is of the instruction-count type and its count is non-zero. When a count steps from one to zero, the trigger records a hit. The unit then emits a one-cycle fire pulse that carries the trigger index and its action code. A summary output tells the core whether any armed trigger matches the present mode, so the core can retire one instruction at a time while one does.

The design has no sequencing state machine. Each trigger slot updates its word in one of three ways: reset to zero, overwritten by software, or counted down on a matching retire. The fire pulse sits in a single output register stage.

Top module: `icnt_trig_unit`

## Requirements
- R1: After reset every control word reads as zero, `fire` is low and `step_req` is low.
- R2: Control word fields:
  - bits 5:0 are the action code;
  - bit 6 enables U, bit 7 enables S, bit 8 is a pending flag that is only stored, and bit 9 enables M;
  - bits 23:10 are a 14-bit count;
  - bit 24 is the hit flag;
  - bit 25 enables VU and bit 26 enables VS;
  - bits 31:28 are the trigger type.

  A write stores the word whole into the selected slot. `rd_data` shows the selected word in the same cycle.
- R3: Only words whose type field equals 3 count. A word of any other type never changes on retire and never fires.
- R4: A type-3 word whose count is zero never changes on retire and never fires.
- R5: On a clock edge with `retire` high, every armed, privilege-matching trigger lowers its count by exactly one.
- R6: Privilege is encoded U=0, S=1, M=3, with 2 matching nothing. When `virt` is low, a trigger matches when the U, S or M enable for the current level is set. The VU and VS bits are ignored.
- R7: When `virt` is high, only VU (for level 0) and VS (for level 1) are checked. The U, S and M bits are ignored.
- R8: A retire that takes a count from 1 to 0 sets that word's hit bit. In the next cycle `fire` is high for exactly one cycle, with `fire_idx` set to the trigger index and `fire_action` set to its action code.
- R9: When several triggers fire on the same edge, `fire_idx` and `fire_action` report the lowest index. Every one of those triggers still sets its hit bit.
- R10: A software write to a slot on the same edge as a retire wins. The slot holds exactly the written value and does not fire on that edge.
- R11: `step_req` is high exactly while at least one armed trigger matches the current `priv`/`virt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_idx | input | IDXW | Index of the selected trigger |
| wr_en | input | 1 | Write strobe for the selected control word |
| wr_data | input | 32 | Value to write |
| rd_data | output | 32 | Selected control word, zero when the index is out of range |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege level (U=0, S=1, M=3) |
| virt | input | 1 | Core is in virtualized mode |
| step_req | output | 1 | Some armed trigger matches the current mode |
| fire | output | 1 | One-cycle trigger fire pulse |
| fire_idx | output | IDXW | Index of the fired trigger |
| fire_action | output | 6 | Action code of the fired trigger |

## Verification
The checker assumes that `retire`, `wr_en` and `sel_idx` are held low or at a defined value throughout reset. It also assumes that `sel_idx` stays below the trigger count whenever the read-back properties are relied on. The bench drives every input on the falling clock edge and keeps the index in range. It clears the whole bank before each scenario, so a fire pulse can only come from the triggers that scenario arms. Stimulus changes `priv` and `virt` only between retires, except for the reserved level 2, which is exercised on purpose.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 14;
    localparam int ACT_W    = 6;
    localparam logic [3:0] KIND_ICOUNT = 4'd3;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // Field order is software visible: it must match the read/write layout.
    typedef struct packed {
        logic [3:0]       kind;
        logic             rsvd;
        logic             en_vs;
        logic             en_vu;
        logic             hit;
        logic [CNT_W-1:0] count;
        logic             en_m;
        logic             pend;
        logic             en_s;
        logic             en_u;
        logic [ACT_W-1:0] action;
    } trig_word_t;
endpackage

// File: rtl/icnt_lvl_match.sv
module icnt_lvl_match
    import icnt_pkg::*;
(
    input  trig_word_t word,
    input  logic [1:0] priv,
    input  logic       virt,
    output logic       match
);
    always_comb begin
        match = 1'b0;
        if (virt) begin
            unique case (lvl_e'(priv))
                LVL_USER:  match = word.en_vu;
                LVL_SUPER: match = word.en_vs;
                LVL_RSVD,
                LVL_MACH:  match = 1'b0;
            endcase
        end else begin
            unique case (lvl_e'(priv))
                LVL_USER:  match = word.en_u;
                LVL_SUPER: match = word.en_s;
                LVL_MACH:  match = word.en_m;
                LVL_RSVD:  match = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/icnt_trig_slot.sv
module icnt_trig_slot
    import icnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  trig_word_t wr_word,
    input  logic       retire,
    input  logic [1:0] priv,
    input  logic       virt,
    output trig_word_t word,
    output logic       live,
    output logic       fire_now
);
    logic match;
    logic armed;

    icnt_lvl_match u_match (
        .word  (word),
        .priv  (priv),
        .virt  (virt),
        .match (match)
    );

    assign armed    = (word.kind == KIND_ICOUNT) && (word.count != '0);
    assign live     = armed && match;
    assign fire_now = retire && live && !wr_hit && (word.count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (wr_hit) begin
            word <= wr_word;
        end else if (retire && live) begin
            word.count <= word.count - CNT_W'(1);
            if (word.count == CNT_W'(1)) begin
                word.hit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/icnt_fire_pick.sv
module icnt_fire_pick #(
    parameter int NUM_TRIG = 4,
    parameter int IDXW     = 2
) (
    input  logic [NUM_TRIG-1:0] req,
    output logic                any,
    output logic [IDXW-1:0]     sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                sel = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/icnt_trig_unit.sv
module icnt_trig_unit
    import icnt_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    localparam int IDXW    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDXW-1:0]   sel_idx,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              retire,
    input  logic [1:0]        priv,
    input  logic              virt,
    output logic              step_req,
    output logic              fire,
    output logic [IDXW-1:0]   fire_idx,
    output logic [ACT_W-1:0]  fire_action
);
    trig_word_t          words [NUM_TRIG];
    logic [NUM_TRIG-1:0] live_vec;
    logic [NUM_TRIG-1:0] fire_vec;
    logic                pick_any;
    logic [IDXW-1:0]     pick_sel;
    logic                sel_ok;

    assign sel_ok = int'(sel_idx) < NUM_TRIG;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        icnt_trig_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_en && sel_ok && (int'(sel_idx) == g)),
            .wr_word  (trig_word_t'(wr_data)),
            .retire   (retire),
            .priv     (priv),
            .virt     (virt),
            .word     (words[g]),
            .live     (live_vec[g]),
            .fire_now (fire_vec[g])
        );
    end

    icnt_fire_pick #(.NUM_TRIG(NUM_TRIG), .IDXW(IDXW)) u_pick (
        .req (fire_vec),
        .any (pick_any),
        .sel (pick_sel)
    );

    assign rd_data  = sel_ok ? WORD_W'(words[sel_idx]) : '0;
    assign step_req = |live_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire        <= 1'b0;
            fire_idx    <= '0;
            fire_action <= '0;
        end else begin
            fire <= pick_any;
            if (pick_any) begin
                fire_idx    <= pick_sel;
                fire_action <= words[pick_sel].action;
            end
        end
    end
endmodule

// File: rtl/icnt_trig_unit_chk.sv
module icnt_trig_unit_chk #(
    parameter int NUM_TRIG = 4,
    parameter int IDXW     = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IDXW-1:0] sel_idx,
    input logic            wr_en,
    input logic [31:0]     wr_data,
    input logic [31:0]     rd_data,
    input logic            retire,
    input logic            fire,
    input logic [IDXW-1:0] fire_idx,
    input logic            step_req
);
    // R8: a fire pulse only follows a retire edge
    assert_fire_after_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(retire));

    // R9: reported index is always a real slot
    assert_fire_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (int'(fire_idx) < NUM_TRIG));

    // R10: a write lands exactly as written when the index stays put
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((sel_idx != $past(sel_idx)) || (rd_data == $past(wr_data))));

    // R5: without retire or write, a selected word does not move
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(retire) && !$past(wr_en) && $stable(sel_idx)) |-> $stable(rd_data));

    // R11: nothing armed and matching means a retire cannot fire
    assert_no_step_no_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !step_req) |=> !fire);

    // R8: fired slot, when selected and not rewritten, shows hit set and count zero
    assert_fired_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (sel_idx == fire_idx) && !$past(wr_en)) |-> (rd_data[24] && (rd_data[23:10] == 14'd0)));
endmodule

bind icnt_trig_unit icnt_trig_unit_chk #(.NUM_TRIG(NUM_TRIG), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_idx  (sel_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .retire   (retire),
    .fire     (fire),
    .fire_idx (fire_idx),
    .step_req (step_req)
);

// File: tb/test_icnt_trig_unit.sv
module test_icnt_trig_unit;
    localparam int N    = 4;
    localparam int IDXW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IDXW-1:0] sel_idx = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic            retire = 1'b0;
    logic [1:0]      priv = 2'd3;
    logic            virt = 1'b0;
    logic            step_req;
    logic            fire;
    logic [IDXW-1:0] fire_idx;
    logic [5:0]      fire_action;

    int checks = 0;
    int fails  = 0;
    logic            got_fire;
    logic [IDXW-1:0] got_idx;
    logic [5:0]      got_act;

    always #4 clk = ~clk;

    icnt_trig_unit #(.NUM_TRIG(N)) i_icnt_trig_unit (
        .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .retire(retire), .priv(priv),
        .virt(virt), .step_req(step_req), .fire(fire), .fire_idx(fire_idx),
        .fire_action(fire_action)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] k, input logic [5:0] act,
                                       input logic u, input logic s, input logic m,
                                       input logic vu, input logic vs, input int cnt);
        logic [31:0] w;
        w = '0;
        w[31:28] = k;  w[5:0] = act;
        w[6] = u;      w[7] = s;     w[9] = m;
        w[25] = vu;    w[26] = vs;   w[23:10] = cnt[13:0];
        return w;
    endfunction

    task automatic wr(input int idx, input logic [31:0] d);
        sel_idx = IDXW'(idx); wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        sel_idx = IDXW'(idx);
        #1 d = rd_data;
    endtask

    task automatic ret(input logic [1:0] p, input logic v);
        priv = p; virt = v; retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        got_fire = fire; got_idx = fire_idx; got_act = fire_action;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr(i, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            check(d == 32'h0, "R1 word zero", d, 0);
        end
        check(fire == 1'b0, "R1 fire low", 32'(fire), 0);
        check(step_req == 1'b0, "R1 step_req low", 32'(step_req), 0);
    endtask

    task automatic t_basic();
        logic [31:0] d, w;
        clear_all();
        w = mk(4'd3, 6'd5, 0, 0, 1, 0, 0, 3);
        w[8] = 1'b1;
        wr(0, w);
        rd(0, d);
        check(d == w, "R2 readback", d, w);
        priv = 2'd3; virt = 1'b0; #1;
        check(step_req, "R11 step_req armed", 32'(step_req), 1);
        ret(2'd3, 1'b0);
        check(!got_fire, "R5 no fire at 2", 32'(got_fire), 0);
        ret(2'd3, 1'b0);
        rd(0, d);
        check(d[23:10] == 14'd1, "R5 count 1", 32'(d[23:10]), 1);
        ret(2'd3, 1'b0);
        check(got_fire && got_idx == 0 && got_act == 6'd5, "R8 fire pulse",
              {got_fire, 23'd0, 2'(got_idx), got_act}, {1'b1, 31'd5});
        rd(0, d);
        check(d[24] && d[23:10] == 0 && d[8], "R8 hit set count zero", d, w | 32'h0100_0000);
        @(negedge clk);
        check(!fire, "R8 one cycle pulse", 32'(fire), 0);
        #1 check(!step_req, "R11 step_req after fire", 32'(step_req), 0);
        ret(2'd3, 1'b0);
        check(!got_fire, "R4 disarmed no fire", 32'(got_fire), 0);
        rd(0, d);
        check(d[23:10] == 0, "R4 count stays zero", 32'(d[23:10]), 0);
    endtask

    task automatic t_priv();
        logic [31:0] d;
        clear_all();
        wr(1, mk(4'd3, 6'd1, 1, 0, 0, 1, 1, 5));
        ret(2'd3, 1'b0);
        ret(2'd1, 1'b0);
        ret(2'd2, 1'b0);
        rd(1, d);
        check(d[23:10] == 14'd5, "R6 mismatched levels hold", 32'(d[23:10]), 5);
        ret(2'd0, 1'b0);
        rd(1, d);
        check(d[23:10] == 14'd4, "R6 U decrement", 32'(d[23:10]), 4);
    endtask

    task automatic t_virt();
        logic [31:0] d;
        clear_all();
        wr(2, mk(4'd3, 6'd2, 1, 0, 1, 0, 1, 4));
        ret(2'd0, 1'b1);
        ret(2'd3, 1'b1);
        rd(2, d);
        check(d[23:10] == 14'd4, "R7 U/M ignored when virt", 32'(d[23:10]), 4);
        ret(2'd1, 1'b1);
        rd(2, d);
        check(d[23:10] == 14'd3, "R7 VS decrement", 32'(d[23:10]), 3);
        ret(2'd1, 1'b0);
        rd(2, d);
        check(d[23:10] == 14'd3, "R6 VS ignored when not virt", 32'(d[23:10]), 3);
        priv = 2'd0; virt = 1'b1; #1;
        check(!step_req, "R11 no match under VU", 32'(step_req), 0);
    endtask

    task automatic t_type();
        logic [31:0] d, w;
        clear_all();
        w = mk(4'd2, 6'd7, 1, 1, 1, 1, 1, 1);
        wr(3, w);
        priv = 2'd3; virt = 1'b0; #1;
        check(!step_req, "R3 other type no step", 32'(step_req), 0);
        ret(2'd3, 1'b0);
        check(!got_fire, "R3 other type no fire", 32'(got_fire), 0);
        rd(3, d);
        check(d == w, "R3 other type unchanged", d, w);
        w = mk(4'd3, 6'd7, 1, 1, 1, 1, 1, 0);
        wr(3, w);
        ret(2'd3, 1'b0);
        rd(3, d);
        check(!got_fire && d == w, "R4 zero count inert", d, w);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        clear_all();
        wr(1, mk(4'd3, 6'd11, 0, 0, 1, 0, 0, 1));
        wr(3, mk(4'd3, 6'd33, 0, 0, 1, 0, 0, 1));
        ret(2'd3, 1'b0);
        check(got_fire && got_idx == 1 && got_act == 6'd11, "R9 lowest index",
              {30'(got_act), 2'(got_idx)}, {30'd11, 2'd1});
        rd(3, d);
        check(d[24] && d[23:10] == 0, "R9 higher slot hit", d, 32'h3100_0000);
    endtask

    task automatic t_wr_prio();
        logic [31:0] d, w;
        clear_all();
        wr(2, mk(4'd3, 6'd9, 0, 0, 1, 0, 0, 1));
        w = mk(4'd3, 6'd9, 0, 0, 1, 0, 0, 5);
        sel_idx = 2'd2; wr_en = 1'b1; wr_data = w;
        priv = 2'd3; virt = 1'b0; retire = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; retire = 1'b0;
        check(!fire, "R10 no fire under write", 32'(fire), 0);
        rd(2, d);
        check(d == w, "R10 written value kept", d, w);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_priv();
        t_virt();
        t_type();
        t_multi();
        t_wr_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule